// File: doc/BRIEF.md
# Extension Channel Busy Estimator

This block estimates how occupied the secondary 20 MHz channel has been since the previous estimate, and gives it as a whole percentage from 0 to 100. Three counters that run freely elsewhere in the chip feed it:
- elapsed clock cycles;
- cycles in which the primary (control) channel was sensed busy;
- cycles in which the secondary channel was sensed busy.

When a sample request arrives, the block subtracts the counter values it stored at the last accepted request from the present values. It stores the present values for the next time. It then outputs one percentage together with a one-cycle valid strobe.

The estimate does not relate secondary-channel busy time to the whole interval. It relates it to the time in which the control channel was clear, because the secondary-channel sense is meaningless while the control channel is occupied. Some cases need no arithmetic and are answered at once: the first sample, a cycle counter that has gone backwards, and an interval with no clear time. In the general case the block scales the extension-busy delta by 100 and divides it in a shift-subtract divider that takes several cycles. While that divider is working, the block ignores further requests.

Top module: `ext_busy_estimator`

## Requirements
- R1: After synchronous active-high reset, `pct_valid` and `calc_busy` are 0, and all stored counter values are zero.
- R2: If the stored cycle value is zero, or is larger than the present `cyc_cnt`, the accepted request yields a result of 0.
- R3: The clear time is the cycle delta minus the control-busy delta when the cycle delta is strictly larger, and zero otherwise. A zero clear time yields a result of 100.
- R4: Otherwise the result is floor(extension-busy delta × 100 / clear time). The product is formed at 8 bits wider than the counters, so it never overflows.
- R5: A quotient above 100 is reported as 100, and `busy_pct` never exceeds 100 while `pct_valid` is high.
- R6: Every accepted request stores the present three counter values, including requests that yield 0.
- R7: The control-busy and extension-busy deltas are unsigned subtractions modulo 2^CNT_W, so a wrapped busy counter gives the correct small delta.
- R8: For results decided without division, `pct_valid` is high in the cycle after the accepting edge. For a division, `calc_busy` is high from the cycle after the accepting edge until the result. `pct_valid` rises CNT_W+9 clock edges after the accepting edge (41 at default) and stays high for one cycle, in the cycle in which `calc_busy` falls.
- R9: A request made while `calc_busy` is high is ignored. It produces no result and leaves the stored counter values unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_req | input | 1 | Request an estimate using the present counter values |
| cyc_cnt | input | CNT_W | Free-running elapsed-cycle counter |
| ctl_busy_cnt | input | CNT_W | Free-running control-channel busy counter |
| ext_busy_cnt | input | CNT_W | Free-running extension-channel busy counter |
| busy_pct | output | 7 | Estimated extension-channel busy percentage, 0..100 |
| pct_valid | output | 1 | One-cycle strobe marking `busy_pct` as new |
| calc_busy | output | 1 | Division in progress; requests are ignored |

## Verification
A stored counter value that is wrong cannot be seen at once. It shows up as a wrong percentage on the next accepted request, so every scenario is followed by a request whose expected value depends on what the previous one stored. The ignored-request case is checked this way, along with the wrapped-counter case. A divider that has lost count or shifted badly shows at the first division: either as a latency other than 41 edges or as a quotient that differs from the exact truncated ratio. A misplaced clamp or zero-clear decision shows in the cycle right after the accepting edge.

// File: rtl/ebe_pkg.sv
package ebe_pkg;

    localparam int PCT_W     = 7;
    localparam int PCT_MAX   = 100;
    localparam int SCALE_W   = 8;

    typedef enum logic [1:0] {
        PATH_ZERO = 2'd0,
        PATH_FULL = 2'd1,
        PATH_DIV  = 2'd2
    } path_e;

    function automatic path_e pick_path(input logic fresh, input logic no_clear);
        if (fresh)
            return PATH_ZERO;
        else if (no_clear)
            return PATH_FULL;
        else
            return PATH_DIV;
    endfunction

endpackage

// File: rtl/ebe_classify.sv
module ebe_classify #(
    parameter int CNT_W = 32,
    parameter int DW    = CNT_W + ebe_pkg::SCALE_W
) (
    input  logic [CNT_W-1:0] cur_cyc,
    input  logic [CNT_W-1:0] cur_ctl,
    input  logic [CNT_W-1:0] cur_ext,
    input  logic [CNT_W-1:0] sv_cyc,
    input  logic [CNT_W-1:0] sv_ctl,
    input  logic [CNT_W-1:0] sv_ext,
    output ebe_pkg::path_e   path,
    output logic [DW-1:0]    dividend,
    output logic [CNT_W-1:0] divisor
);
    logic [CNT_W-1:0] cyc_d, ctl_d, ext_d, clear_d;
    logic             fresh;

    always_comb begin
        cyc_d    = cur_cyc - sv_cyc;
        ctl_d    = cur_ctl - sv_ctl;
        ext_d    = cur_ext - sv_ext;
        fresh    = (sv_cyc == '0) || (sv_cyc > cur_cyc);
        clear_d  = (cyc_d > ctl_d) ? (cyc_d - ctl_d) : '0;
        path     = ebe_pkg::pick_path(fresh, clear_d == '0);
        dividend = DW'(ext_d) * DW'(ebe_pkg::PCT_MAX);
        divisor  = clear_d;
    end
endmodule

// File: rtl/ebe_divider.sv
module ebe_divider #(
    parameter int CNT_W = 32,
    parameter int DW    = CNT_W + ebe_pkg::SCALE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DW-1:0]    dividend,
    input  logic [CNT_W-1:0] divisor,
    output logic [DW-1:0]    quotient,
    output logic             active,
    output logic             done
);
    localparam int CW = $clog2(DW + 1);

    logic [CNT_W:0]   rem;
    logic [CNT_W-1:0] dvs;
    logic [CW-1:0]    steps_left;
    logic [CNT_W:0]   trial;
    logic             fits;

    always_comb begin
        trial = {rem[CNT_W-1:0], quotient[DW-1]};
        fits  = trial >= {1'b0, dvs};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem        <= '0;
            dvs        <= '0;
            quotient   <= '0;
            steps_left <= '0;
            active     <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem        <= '0;
                dvs        <= divisor;
                quotient   <= dividend;
                steps_left <= CW'(DW);
                active     <= 1'b1;
            end else if (active) begin
                rem        <= fits ? (trial - {1'b0, dvs}) : trial;
                quotient   <= {quotient[DW-2:0], fits};
                steps_left <= steps_left - 1'b1;
                if (steps_left == CW'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    // R9: the top never restarts a division in flight
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);

    // R4: a finished restoring division leaves a remainder below the divisor
    assert_rem_below_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem < {1'b0, dvs}));

    // R8: completion follows an active step
    assert_done_after_active_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(active));
endmodule

// File: rtl/ext_busy_estimator.sv
module ext_busy_estimator #(
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      sample_req,
    input  logic [CNT_W-1:0]          cyc_cnt,
    input  logic [CNT_W-1:0]          ctl_busy_cnt,
    input  logic [CNT_W-1:0]          ext_busy_cnt,
    output logic [ebe_pkg::PCT_W-1:0] busy_pct,
    output logic                      pct_valid,
    output logic                      calc_busy
);
    import ebe_pkg::*;

    localparam int DW = CNT_W + SCALE_W;

    logic [CNT_W-1:0] saved_cyc, saved_ctl, saved_ext;
    path_e            path;
    logic [DW-1:0]    dividend, quotient;
    logic [CNT_W-1:0] divisor;
    logic             accept, start, div_active, div_done;
    logic [PCT_W-1:0] clamped;

    ebe_classify #(.CNT_W(CNT_W), .DW(DW)) u_classify (
        .cur_cyc  (cyc_cnt),
        .cur_ctl  (ctl_busy_cnt),
        .cur_ext  (ext_busy_cnt),
        .sv_cyc   (saved_cyc),
        .sv_ctl   (saved_ctl),
        .sv_ext   (saved_ext),
        .path     (path),
        .dividend (dividend),
        .divisor  (divisor)
    );

    ebe_divider #(.CNT_W(CNT_W), .DW(DW)) u_divider (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .dividend (dividend),
        .divisor  (divisor),
        .quotient (quotient),
        .active   (div_active),
        .done     (div_done)
    );

    always_comb begin
        calc_busy = div_active | div_done;
        accept    = sample_req & ~calc_busy;
        start     = accept && (path == PATH_DIV);
        clamped   = (quotient > DW'(PCT_MAX)) ? PCT_W'(PCT_MAX) : quotient[PCT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_cyc <= '0;
            saved_ctl <= '0;
            saved_ext <= '0;
        end else if (accept) begin
            saved_cyc <= cyc_cnt;
            saved_ctl <= ctl_busy_cnt;
            saved_ext <= ext_busy_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_pct  <= '0;
            pct_valid <= 1'b0;
        end else begin
            pct_valid <= 1'b0;
            if (accept && (path != PATH_DIV)) begin
                busy_pct  <= (path == PATH_ZERO) ? '0 : PCT_W'(PCT_MAX);
                pct_valid <= 1'b1;
            end else if (div_done) begin
                busy_pct  <= clamped;
                pct_valid <= 1'b1;
            end
        end
    end

    assert_pct_bound_R5: assert property (@(posedge clk) disable iff (rst)
        pct_valid |-> (busy_pct <= PCT_W'(PCT_MAX)));

    assert_first_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && saved_cyc == '0) |=> (pct_valid && busy_pct == '0));

    assert_save_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
        accept |=> (saved_cyc == $past(cyc_cnt) && saved_ctl == $past(ctl_busy_cnt)
                    && saved_ext == $past(ext_busy_cnt)));

    assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (sample_req && calc_busy) |=> ($stable(saved_cyc) && $stable(saved_ctl)
                                       && $stable(saved_ext)));

    assert_result_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(calc_busy) |-> pct_valid);
endmodule

// File: tb/ext_busy_estimator_bench.sv
`timescale 1ns/1ps
module ext_busy_estimator_bench;
    localparam int CNT_W   = 32;
    localparam int DIV_LAT = CNT_W + 10; // edges counted including the accepting one

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sample_req = 1'b0;
    logic [CNT_W-1:0] cyc_cnt = '0, ctl_busy_cnt = '0, ext_busy_cnt = '0;
    logic [6:0]       busy_pct;
    logic             pct_valid, calc_busy;

    int errors = 0;
    int checks = 0;
    logic [CNT_W-1:0] m_cyc = '0, m_ctl = '0, m_ext = '0;

    always #4 clk = ~clk;

    ext_busy_estimator #(.CNT_W(CNT_W)) u_ext_busy_estimator (
        .clk(clk), .rst(rst), .sample_req(sample_req),
        .cyc_cnt(cyc_cnt), .ctl_busy_cnt(ctl_busy_cnt), .ext_busy_cnt(ext_busy_cnt),
        .busy_pct(busy_pct), .pct_valid(pct_valid), .calc_busy(calc_busy)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model from the requirements; also updates the modelled stored values.
    task automatic model(input logic [CNT_W-1:0] c, b, e,
                         output int pct, output bit divides);
        logic [CNT_W-1:0] cd, bd, ed, clr;
        longint q;
        divides = 1'b0;
        if (m_cyc == '0 || m_cyc > c) pct = 0;
        else begin
            cd = c - m_cyc; bd = b - m_ctl; ed = e - m_ext;
            clr = (cd > bd) ? cd - bd : '0;
            if (clr == '0) pct = 100;
            else begin
                divides = 1'b1;
                q = (longint'(ed) * 100) / longint'(clr);
                pct = (q > 100) ? 100 : int'(q);
            end
        end
        m_cyc = c; m_ctl = b; m_ext = e;
    endtask

    // One accepted request; checks value, latency and single-cycle strobe.
    task automatic request(input string req, input logic [CNT_W-1:0] c, b, e);
        int exp_pct; bit divides; int n;
        model(c, b, e, exp_pct, divides);
        @(negedge clk);
        cyc_cnt = c; ctl_busy_cnt = b; ext_busy_cnt = e; sample_req = 1'b1;
        @(posedge clk); n = 1;
        @(negedge clk); sample_req = 1'b0;
        if (divides) check({req, " R8 busy during divide"}, calc_busy, 1);
        while (!pct_valid && n < DIV_LAT + 20) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
        check({req, " value"}, busy_pct, exp_pct);
        check({req, " R8 latency"}, n, divides ? DIV_LAT : 1);
        @(negedge clk);
        check({req, " R8 single strobe"}, pct_valid, 0);
        check({req, " R8 idle after"}, calc_busy, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid after reset", pct_valid, 0);
        check("R1 busy after reset", calc_busy, 0);
    endtask

    task automatic t_first();   // R1 R2: stored values zero, so first result is 0
        request("R2 first sample", 32'd1000, 32'd100, 32'd50);
    endtask

    task automatic t_basic();   // R4: 70*100/700 = 10, then 333*100/1000 = 33
        request("R4 ratio", 32'd2000, 32'd400, 32'd120);
        request("R4 truncation", 32'd3000, 32'd400, 32'd453);
    endtask

    task automatic t_no_clear(); // R3: equal and smaller cycle delta
        request("R3 equal deltas", 32'd3100, 32'd500, 32'd460);
        request("R3 busy exceeds cycles", 32'd3200, 32'd700, 32'd470);
    endtask

    task automatic t_clamp();   // R5: 50*100/10 = 500 -> 100
        request("R5 clamp", 32'd3300, 32'd790, 32'd520);
    endtask

    task automatic t_wrap();    // R2 R6: backwards cycle counter, then use of stored values
        request("R2 wrap", 32'd100, 32'd10, 32'd5);
        request("R6 stored after wrap", 32'd300, 32'd60, 32'd35);  // 30*100/150 = 20
    endtask

    task automatic t_wide();    // R4: product exceeds 32 bits; 0x40000000*100/0x80000000 = 50
        request("R4 wide product", 32'd300 + 32'h8000_0000, 32'd60, 32'h4000_0023);
    endtask

    task automatic t_busy_wrap(); // R7: control counter wraps, delta 512; 250*100/1000 = 25
        request("R7 setup", 32'h8001_0000, 32'hFFFF_FF00, 32'h4000_0100);
        request("R7 modulo delta", 32'h8001_0000 + 32'd1512, 32'h0000_0100, 32'h4000_01FA);
    endtask

    task automatic t_ignore();  // R9: request during division has no effect
        int exp_pct; bit divides; int pulses;
        logic [CNT_W-1:0] c, b, e;
        c = m_cyc + 32'd400; b = m_ctl + 32'd200; e = m_ext + 32'd100; // 100*100/200 = 50
        model(c, b, e, exp_pct, divides);
        @(negedge clk);
        cyc_cnt = c; ctl_busy_cnt = b; ext_busy_cnt = e; sample_req = 1'b1;
        @(negedge clk);
        cyc_cnt = c + 32'd9; ctl_busy_cnt = b + 32'd3; ext_busy_cnt = e + 32'd7;
        @(negedge clk); sample_req = 1'b0;
        pulses = 0;
        for (int i = 0; i < DIV_LAT + 10; i++) begin
            @(negedge clk);
            if (pct_valid) begin
                pulses++;
                check("R9 first result value", busy_pct, exp_pct);
            end
        end
        check("R9 one result only", pulses, 1);
        // stored values must be those of the first request: 250*100/500 = 50
        request("R9 stored unchanged", c + 32'd1000, b + 32'd500, e + 32'd250);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_first();
        t_basic();
        t_no_clear();
        t_clamp();
        t_wrap();
        t_wide();
        t_busy_wrap();
        t_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule